// File: doc/BRIEF.md
# Receive Bus Frame Timebase

This block keeps the bit, time-slot and frame count for a receive-side PCM system bus. The bus clock comes from one of two clock inputs. A frame has 32 time slots of 8 bits each, which is 256 bit times, and 16 frames make a multiframe. Downstream logic reads the current bit index, time-slot index and frame index from the block, together with a strobe that marks the last clock of each bit time. In double-rate mode each data bit lasts two bus clocks.

The block works in one of two roles:

- **Master:** it drives a single sync pin. The pin carries either the frame pulse or the multiframe pulse, chosen by configuration. The pulse sits at a programmable time-slot and bit position inside the frame, and it can be launched on the rising or the falling clock edge.
- **Slave:** the same sync function arrives as an input. The counters jump to the configured position when a sync pulse starts. A sticky flag records any later pulse that arrives somewhere else.

All configuration is static and must be set while reset is held.

Top module: `rxtb_timebase`

## Requirements
- R1: The counters run from `clk_tx_bus` when `cfg_clk_sel` is 1 and from `clk_rx_bus` when it is 0; the unselected clock has no effect.
- R2: The position advances by one bit time at a time. `bit_o` counts 0..7, `ts_o` counts 0..31 and increments when the bit index wraps, and `frame_o` counts 0..15 and increments when the time slot wraps. All three read 0 during reset, and the first clock after reset gives bit 1 (or phase 1 of bit 0 in double-rate mode).
- R3: With `cfg_x2`=0, `bit_en_o` is 1 on every clock. With `cfg_x2`=1, every bit index holds for two clocks and `bit_en_o` is 1 only on the second of them.
- R4: In master mode with `cfg_pin_multi`=0, `sync_o` is 1 exactly while `ts_o`=`cfg_ts_off` and `bit_o`=`cfg_bit_off`, in every frame.
- R5: In master mode with `cfg_pin_multi`=1, `sync_o` is 1 under the same position condition, but only while `frame_o`=0.
- R6: `cfg_pin_multi` selects which of the two pulses appears on the single sync pin, and in slave mode which function `sync_i` carries.
- R7: With `cfg_fall_edge`=0, `sync_o` changes just after the rising edge. With `cfg_fall_edge`=1, it shows the same value half a clock later, launched on the falling edge.
- R8: In slave mode `sync_o` stays 0. A clock that samples `sync_i`=1 after a sampled 0 loads bit=`cfg_bit_off`, time slot=`cfg_ts_off` and phase 0. When `cfg_pin_multi`=1 it also loads frame 0; otherwise the frame index keeps advancing.
- R9: `misalign_o` is set by any sync start in slave mode that comes after the first one and does not land on the position the counters would have reached anyway. It stays set until reset, and the first sync start after reset never sets it.
- R10: During reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rx_bus | input | 1 | Receive bus clock candidate |
| clk_tx_bus | input | 1 | Transmit bus clock candidate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_clk_sel | input | 1 | 1 selects clk_tx_bus as the bus clock |
| cfg_master | input | 1 | 1 = timebase drives sync, 0 = follows sync_i |
| cfg_x2 | input | 1 | Bus clock runs at twice the bit rate |
| cfg_pin_multi | input | 1 | Sync pin carries the multiframe pulse instead of the frame pulse |
| cfg_fall_edge | input | 1 | Launch sync_o on the falling edge |
| cfg_ts_off | input | 5 | Time-slot position of the sync pulse |
| cfg_bit_off | input | 3 | Bit position of the sync pulse |
| sync_i | input | 1 | Incoming sync (slave mode) |
| sync_o | output | 1 | Outgoing sync (master mode) |
| ts_o | output | 5 | Current time-slot index |
| bit_o | output | 3 | Current bit index |
| frame_o | output | 4 | Current frame within the multiframe |
| bit_en_o | output | 1 | Last clock of the current bit time |
| misalign_o | output | 1 | Sticky: a sync arrived at an unexpected position |

## Verification
The hardest state to reach is a slave that has already locked and then receives one stray sync start, because the misalignment flag must stay clear both on the first lock and on every correctly timed pulse that follows.

The bench reaches this state in three steps:

1. It injects one sync at an arbitrary cycle to make the first lock.
2. From then on, it drives `sync_i` from its own model of where the counters will be, so every later pulse lands on the expected position.
3. It injects a second pulse at a cycle picked so that it falls between the correct pulses.

In multiframe slave mode with double-rate timing, a correct pulse comes only once every 8192 clocks, so that run is long enough to see two of them.

// File: rtl/rxtb_pkg.sv
package rxtb_pkg;

    // Function carried by the single sync pin
    typedef enum logic {
        PIN_FRAME = 1'b0,
        PIN_MULTI = 1'b1
    } pin_role_e;

    // Role of the timebase on the bus
    typedef enum logic {
        ROLE_SLAVE  = 1'b0,
        ROLE_MASTER = 1'b1
    } bus_role_e;

endpackage

// File: rtl/rxtb_clk_sel.sv
module rxtb_clk_sel (
    input  logic clk_a_i,
    input  logic clk_b_i,
    input  logic sel_i,
    output logic clk_o
);

    // Static selection; it only changes while the timebase is held in reset
    assign clk_o = sel_i ? clk_b_i : clk_a_i;

endmodule

// File: rtl/rxtb_pos_next.sv
module rxtb_pos_next #(
    parameter  int BIT_NUM = 8,
    parameter  int TS_NUM  = 32,
    parameter  int FRM_NUM = 16,
    localparam int BW      = $clog2(BIT_NUM),
    localparam int TW      = $clog2(TS_NUM),
    localparam int FW      = $clog2(FRM_NUM)
) (
    input  logic          x2_i,
    input  logic          ph_i,
    input  logic [BW-1:0] bit_i,
    input  logic [TW-1:0] ts_i,
    input  logic [FW-1:0] fr_i,
    output logic          ph_o,
    output logic [BW-1:0] bit_o,
    output logic [TW-1:0] ts_o,
    output logic [FW-1:0] fr_o
);

    localparam logic [BW-1:0] BIT_LAST = BW'(BIT_NUM - 1);
    localparam logic [TW-1:0] TS_LAST  = TW'(TS_NUM - 1);
    localparam logic [FW-1:0] FR_LAST  = FW'(FRM_NUM - 1);

    logic bit_wrap;
    logic ts_wrap;

    always_comb begin
        ph_o     = ph_i;
        bit_o    = bit_i;
        ts_o     = ts_i;
        fr_o     = fr_i;
        bit_wrap = 1'b0;
        ts_wrap  = 1'b0;
        if (x2_i && !ph_i) begin
            // first clock of a double-rate bit: hold position
            ph_o = 1'b1;
        end else begin
            ph_o = 1'b0;
            if (bit_i == BIT_LAST) begin
                bit_o    = '0;
                bit_wrap = 1'b1;
            end else begin
                bit_o = bit_i + 1'b1;
            end
            if (bit_wrap) begin
                if (ts_i == TS_LAST) begin
                    ts_o    = '0;
                    ts_wrap = 1'b1;
                end else begin
                    ts_o = ts_i + 1'b1;
                end
            end
            if (ts_wrap) begin
                if (fr_i == FR_LAST) begin
                    fr_o = '0;
                end else begin
                    fr_o = fr_i + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/rxtb_sync_launch.sv
module rxtb_sync_launch (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_i,
    input  logic fall_i,
    output logic sync_o
);

    logic neg_q;

    // Retime the rising-edge pulse onto the falling edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            neg_q <= 1'b0;
        end else begin
            neg_q <= pulse_i;
        end
    end

    assign sync_o = fall_i ? neg_q : pulse_i;

endmodule

// File: rtl/rxtb_timebase.sv
module rxtb_timebase #(
    parameter  int BIT_NUM = 8,
    parameter  int TS_NUM  = 32,
    parameter  int FRM_NUM = 16,
    localparam int BW      = $clog2(BIT_NUM),
    localparam int TW      = $clog2(TS_NUM),
    localparam int FW      = $clog2(FRM_NUM)
) (
    input  logic          clk_rx_bus,
    input  logic          clk_tx_bus,
    input  logic          rst_n,
    input  logic          cfg_clk_sel,
    input  logic          cfg_master,
    input  logic          cfg_x2,
    input  logic          cfg_pin_multi,
    input  logic          cfg_fall_edge,
    input  logic [TW-1:0] cfg_ts_off,
    input  logic [BW-1:0] cfg_bit_off,
    input  logic          sync_i,
    output logic          sync_o,
    output logic [TW-1:0] ts_o,
    output logic [BW-1:0] bit_o,
    output logic [FW-1:0] frame_o,
    output logic          bit_en_o,
    output logic          misalign_o
);

    import rxtb_pkg::*;

    typedef struct packed {
        logic          ph;
        logic [BW-1:0] bpos;
        logic [TW-1:0] ts;
        logic [FW-1:0] fr;
        logic          bit_en;
        logic          pulse;
        logic          sync_prev;
        logic          locked;
        logic          misalign;
    } tb_state_t;

    tb_state_t st_d, st_q;

    logic bus_clk;

    logic          adv_ph;
    logic [BW-1:0] adv_bit;
    logic [TW-1:0] adv_ts;
    logic [FW-1:0] adv_fr;

    pin_role_e pin_role;
    bus_role_e bus_role;

    logic sync_rise;
    logic slave_hit;
    logic at_offset;
    logic fs_hit;
    logic ms_hit;

    assign pin_role = pin_role_e'(cfg_pin_multi);
    assign bus_role = bus_role_e'(cfg_master);

    rxtb_clk_sel u_clk_sel (
        .clk_a_i (clk_rx_bus),
        .clk_b_i (clk_tx_bus),
        .sel_i   (cfg_clk_sel),
        .clk_o   (bus_clk)
    );

    rxtb_pos_next #(
        .BIT_NUM (BIT_NUM),
        .TS_NUM  (TS_NUM),
        .FRM_NUM (FRM_NUM)
    ) u_pos_next (
        .x2_i  (cfg_x2),
        .ph_i  (st_q.ph),
        .bit_i (st_q.bpos),
        .ts_i  (st_q.ts),
        .fr_i  (st_q.fr),
        .ph_o  (adv_ph),
        .bit_o (adv_bit),
        .ts_o  (adv_ts),
        .fr_o  (adv_fr)
    );

    always_comb begin
        st_d = st_q;

        // Start of an incoming sync pulse
        sync_rise = sync_i && !st_q.sync_prev;
        slave_hit = (bus_role == ROLE_SLAVE) && sync_rise;

        // Would the free-running count already sit on the sync position?
        at_offset = !adv_ph && (adv_ts == cfg_ts_off) && (adv_bit == cfg_bit_off)
                    && ((pin_role == PIN_FRAME) || (adv_fr == '0));

        st_d.ph   = adv_ph;
        st_d.bpos = adv_bit;
        st_d.ts   = adv_ts;
        st_d.fr   = adv_fr;

        if (slave_hit) begin
            st_d.ph   = 1'b0;
            st_d.bpos = cfg_bit_off;
            st_d.ts   = cfg_ts_off;
            if (pin_role == PIN_MULTI) begin
                st_d.fr = '0;
            end
        end

        st_d.sync_prev = sync_i;
        st_d.locked    = st_q.locked | slave_hit;
        st_d.misalign  = st_q.misalign | (slave_hit && st_q.locked && !at_offset);

        st_d.bit_en = !cfg_x2 || st_d.ph;

        fs_hit = (st_d.ts == cfg_ts_off) && (st_d.bpos == cfg_bit_off);
        ms_hit = fs_hit && (st_d.fr == '0);

        st_d.pulse = (bus_role == ROLE_MASTER)
                     && ((pin_role == PIN_MULTI) ? ms_hit : fs_hit);
    end

    always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    rxtb_sync_launch u_launch (
        .clk     (bus_clk),
        .rst_n   (rst_n),
        .pulse_i (st_q.pulse),
        .fall_i  (cfg_fall_edge),
        .sync_o  (sync_o)
    );

    assign ts_o       = st_q.ts;
    assign bit_o      = st_q.bpos;
    assign frame_o    = st_q.fr;
    assign bit_en_o   = st_q.bit_en;
    assign misalign_o = st_q.misalign;

endmodule

// File: rtl/rxtb_timebase_chk.sv
module rxtb_timebase_chk #(
    parameter int BIT_NUM = 8,
    parameter int BW      = 3,
    parameter int TW      = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_master,
    input logic          cfg_x2,
    input logic          cfg_fall_edge,
    input logic [TW-1:0] cfg_ts_off,
    input logic [BW-1:0] cfg_bit_off,
    input logic          sync_o,
    input logic          bit_en_o,
    input logic [BW-1:0] bit_o,
    input logic [TW-1:0] ts_o,
    input logic          misalign_o
);

    localparam logic [BW-1:0] BIT_LAST = BW'(BIT_NUM - 1);

    logic live_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= 1'b0;
        end else begin
            live_q <= 1'b1;
        end
    end

    // R3
    x1_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !cfg_x2) |-> bit_en_o);

    // R3
    x2_strobe_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_x2 && bit_en_o) |=> !bit_en_o);

    // R2
    bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && bit_en_o && (bit_o != BIT_LAST)) |=> (bit_o == BW'($past(bit_o) + 1'b1)));

    // R4
    sync_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && !cfg_fall_edge && $rose(sync_o)) |-> ((ts_o == cfg_ts_off) && (bit_o == cfg_bit_off)));

    // R8
    slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_master |-> !sync_o);

    // R9
    misalign_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_o |=> misalign_o);

endmodule

bind rxtb_timebase rxtb_timebase_chk #(
    .BIT_NUM (BIT_NUM),
    .BW      (BW),
    .TW      (TW)
) u_chk (
    .clk           (bus_clk),
    .rst_n         (rst_n),
    .cfg_master    (cfg_master),
    .cfg_x2        (cfg_x2),
    .cfg_fall_edge (cfg_fall_edge),
    .cfg_ts_off    (cfg_ts_off),
    .cfg_bit_off   (cfg_bit_off),
    .sync_o        (sync_o),
    .bit_en_o      (bit_en_o),
    .bit_o         (bit_o),
    .ts_o          (ts_o),
    .misalign_o    (misalign_o)
);

// File: tb/rxtb_timebase_tb.sv
`timescale 1ns/1ps
module rxtb_timebase_tb;

    logic       clk_b = 1'b0;
    logic       a_en  = 1'b1;
    logic       clk_a;
    logic       rst_n = 1'b0;
    logic       cfg_clk_sel = 1'b0;
    logic       cfg_master = 1'b1;
    logic       cfg_x2 = 1'b0;
    logic       cfg_pin_multi = 1'b0;
    logic       cfg_fall_edge = 1'b0;
    logic [4:0] cfg_ts_off = '0;
    logic [2:0] cfg_bit_off = '0;
    logic       sync_i = 1'b0;
    logic       sync_o;
    logic [4:0] ts_o;
    logic [2:0] bit_o;
    logic [3:0] frame_o;
    logic       bit_en_o;
    logic       misalign_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // model state
    int m_t, m_ph, m_mis, m_lock, prev_sync, cur_sync, pin_prev;
    int inj1, inj2, pending, policy_on;

    always #5 clk_b = ~clk_b;
    assign clk_a = clk_b & a_en;

    rxtb_timebase u_dut (
        .clk_rx_bus    (clk_a),
        .clk_tx_bus    (clk_b),
        .rst_n         (rst_n),
        .cfg_clk_sel   (cfg_clk_sel),
        .cfg_master    (cfg_master),
        .cfg_x2        (cfg_x2),
        .cfg_pin_multi (cfg_pin_multi),
        .cfg_fall_edge (cfg_fall_edge),
        .cfg_ts_off    (cfg_ts_off),
        .cfg_bit_off   (cfg_bit_off),
        .sync_i        (sync_i),
        .sync_o        (sync_o),
        .ts_o          (ts_o),
        .bit_o         (bit_o),
        .frame_o       (frame_o),
        .bit_en_o      (bit_en_o),
        .misalign_o    (misalign_o)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int nxt_t(int tt, int pp);
        if (cfg_x2 && pp == 0) return tt;
        return (tt + 1) % 4096;
    endfunction

    function automatic int nxt_p(int pp);
        return (cfg_x2 && pp == 0) ? 1 : 0;
    endfunction

    // sync position match: time slot, bit, and frame 0 for multiframe
    function automatic int pos_match(int tt);
        return ((tt / 8) % 32 == int'(cfg_ts_off)) && (tt % 8 == int'(cfg_bit_off))
               && (!cfg_pin_multi || tt / 256 == 0);
    endfunction

    function automatic int pin_exp(int tt);
        return cfg_master && pos_match(tt);
    endfunction

    task automatic run(input bit master, input bit x2, input bit multi, input bit fall,
                       input int ts_off, input int bit_off, input bit csel,
                       input int ncyc, input int i1, input int i2);
        string ptag;
        string stag;
        rst_n = 1'b0;
        @(posedge clk_b);
        #6;
        cfg_master = master; cfg_x2 = x2; cfg_pin_multi = multi; cfg_fall_edge = fall;
        cfg_ts_off = 5'(ts_off); cfg_bit_off = 3'(bit_off); cfg_clk_sel = csel;
        a_en = !csel; sync_i = 1'b0;
        @(posedge clk_b);
        #6;
        // R10 reset state
        chk("R10 ts", ts_o, 0);
        chk("R10 bit", bit_o, 0);
        chk("R10 frame", frame_o, 0);
        chk("R10 sync", sync_o, 0);
        chk("R10 bit_en", bit_en_o, 0);
        chk("R10 misalign", misalign_o, 0);
        m_t = 0; m_ph = 0; m_mis = 0; m_lock = 0; prev_sync = 0; cur_sync = 0; pin_prev = 0;
        inj1 = i1; inj2 = i2; pending = 0; policy_on = 0;
        rst_n = 1'b1;
        ptag = csel ? "R1 position" : "R2 position";
        stag = !master ? "R8 sync" : (multi ? "R5 R6 sync" : "R4 R6 sync");
        for (int c = 0; c < ncyc; c++) begin
            int nt, np, rise, at;
            @(posedge clk_b);
            rise = cur_sync && !prev_sync;
            prev_sync = cur_sync;
            nt = nxt_t(m_t, m_ph);
            np = nxt_p(m_ph);
            at = (np == 0) && pos_match(nt);
            if (!master && rise) begin
                // R8 load, R9 flag
                if (m_lock && !at) m_mis = 1;
                m_lock = 1;
                nt = (multi ? 0 : (nt / 256)) * 256 + ts_off * 8 + bit_off;
                np = 0;
            end
            m_t = nt; m_ph = np;
            #2;
            // R7 launch edge: falling mode still shows previous cycle here
            chk("R7 early sync", sync_o, fall ? pin_prev : pin_exp(m_t));
            #4;
            chk({ptag, " ts"}, ts_o, (m_t / 8) % 32);
            chk({ptag, " bit"}, bit_o, m_t % 8);
            chk({ptag, " frame"}, frame_o, m_t / 256);
            chk("R3 bit_en", bit_en_o, (!x2 || m_ph == 1) ? 1 : 0);
            chk(stag, sync_o, pin_exp(m_t));
            chk("R9 misalign", misalign_o, m_mis);
            pin_prev = pin_exp(m_t);
            // next sync_i value
            begin
                int drv;
                drv = 0;
                if (!master) begin
                    if (policy_on && pos_match(nxt_t(m_t, m_ph))) drv = 1;
                    if (c + 1 == inj1 || c + 1 == inj2) pending = 1;
                    if (pending && drv == 0 && cur_sync == 0) begin
                        drv = 1; pending = 0; policy_on = 1;
                    end
                end
                cur_sync = drv;
                sync_i = drv[0];
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // directed corners
        run(1, 0, 0, 0, 0, 0, 0, 4200, 0, 0);       // frame sync at boundary
        run(1, 1, 1, 1, 31, 7, 0, 8300, 0, 0);      // last slot/bit, 2x, falling, multiframe wrap
        run(1, 0, 1, 0, 5, 3, 1, 4200, 0, 0);       // second clock source only
        run(0, 0, 0, 0, 10, 2, 0, 3000, 50, 2000);  // slave frame sync
        run(0, 1, 1, 1, 3, 6, 0, 16600, 40, 12000); // slave multiframe 2x
        // random configurations
        for (int k = 0; k < 4; k++) begin
            bit ms;
            ms = 1'($urandom % 2);
            run(ms, 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2),
                int'($urandom % 32), int'($urandom % 8), 1'($urandom % 2),
                4500, 10 + int'($urandom % 300), 3000 + int'($urandom % 1000));
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule